// File: doc/BRIEF.md
# Ripple Magnitude Comparator

This block decides how two unsigned operands of a configurable width relate to each other. It does so with a chain of identical one-bit cells. Each cell looks at one bit of each operand and at a two-bit status from the cell below it. It then hands a new status to the cell above. The chain begins at bit 0, where the incoming status is a constant "equal", and ends at the top bit. The status leaving the top cell is the answer. The block is purely combinational.

The status code has two bits. The upper bit set means the first operand is larger so far, and the lower bit set means it is smaller so far. When both bits are clear, the bits seen so far are equal. A cell whose two operand bits differ overrides whatever status it receives. A cell whose bits match passes its incoming status through unchanged. As a result, the most significant differing bit decides the outcome.

A parameter selects how each cell is built. One choice is a two-level AND-OR form. The other is a factored form made only of two-input NAND gates, in which the "A high, B low" and "A low, B high" terms are formed once and feed both outputs. Both forms give the same function. The factored form has fewer gates but one more gate level from the operand bits.

Top module: `ripple_mag_cmp`

## Requirements
- R1: When opA is greater than opB (unsigned), resCode equals 2'b10.
- R2: When opA is less than opB (unsigned), resCode equals 2'b01.
- R3: When opA equals opB, resCode equals 2'b00.
- R4: The code 2'b11 never appears on resCode, nor on any cell output inside the chain.
- R5: Exactly one of aGreater, aLess and aEqual is high, and it is the one that matches resCode (10 gives aGreater, 01 gives aLess, 00 gives aEqual).
- R6: Cell rule: a cell with A=1, B=0 outputs {gt,lt}=10 for any incoming code, and a cell with A=0, B=1 outputs 01 for any incoming code. A cell with equal bits outputs its incoming code unchanged, for all 16 input combinations.
- R7: The AND-OR cell computes gt = A·B' + A·inGt + B'·inGt and lt = A'·B + A'·inLt + B·inLt.
- R8: The all-NAND cell gives the same {gt,lt} as the AND-OR cell for every one of the 16 combinations of {A,B,inGt,inLt}. A comparator built with it (SLICE_FORM=1) matches one built with the AND-OR cell (SLICE_FORM=0) for every operand pair.
- R9: The cell at bit 0 receives code 00, so a one-bit comparator gives 10 for A=1,B=0, gives 01 for A=0,B=1, and gives 00 for equal bits.
- R10: The status ripples upward from bit 0, so the highest differing bit decides. Examples: opA=0x80000000 against opB=0x7FFFFFFF gives 10, and opA=0xFFFFFFFE against opB=0xFFFFFFFF gives 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First unsigned operand |
| opB | input | WIDTH | Second unsigned operand |
| resCode | output | 2 | Result code: 10 greater, 01 less, 00 equal |
| aGreater | output | 1 | High when opA > opB |
| aLess | output | 1 | High when opA < opB |
| aEqual | output | 1 | High when opA == opB |

## Verification
The cell-level checks assume that the incoming status of every cell is itself a legal code, never 11. This holds inside the chain only because bit 0 is tied to 00. The bench feeds isolated cells all 16 input combinations, including an incoming 11, and compares the results against the cell equations rather than against that assumption. The operand-level checks assume fully driven two-valued operands. The stimulus drives every operand bit on each step, sweeping all pairs at four bits and one bit and applying random, equal and single-bit-apart pairs at 32 bits.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  localparam int FORM_SOP  = 0;
  localparam int FORM_NAND = 1;

  typedef enum logic [1:0] {
    CODE_EQ  = 2'b00,
    CODE_LT  = 2'b01,
    CODE_GT  = 2'b10,
    CODE_BAD = 2'b11
  } cmpCode_e;

  typedef struct packed {
    logic gt;
    logic lt;
  } cmpLink_t;

  localparam cmpLink_t LINK_EQUAL = '{gt: 1'b0, lt: 1'b0};

endpackage

// File: rtl/cmp_slice_sop.sv
module cmp_slice_sop (
  input  logic aBit,
  input  logic bBit,
  input  logic inGt,
  input  logic inLt,
  output logic outGt,
  output logic outLt
);

  always_comb begin
    outGt = (aBit & ~bBit) | (aBit & inGt) | (~bBit & inGt);
    outLt = (~aBit & bBit) | (~aBit & inLt) | (bBit & inLt);
  end

endmodule

// File: rtl/cmp_slice_nand.sv
module cmp_slice_nand (
  input  logic aBit,
  input  logic bBit,
  input  logic inGt,
  input  logic inLt,
  output logic outGt,
  output logic outLt
);

  logic aInv, bInv;
  logic nAboveB;
  logic nBelowB;
  logic nKeepGt;
  logic nKeepLt;

  always_comb begin
    aInv    = ~(aBit & aBit);
    bInv    = ~(bBit & bBit);
    nAboveB = ~(aBit & bInv);
    nBelowB = ~(aInv & bBit);
    nKeepGt = ~(nBelowB & inGt);
    nKeepLt = ~(nAboveB & inLt);
    outGt   = ~(nAboveB & nKeepGt);
    outLt   = ~(nBelowB & nKeepLt);
  end

endmodule

// File: rtl/cmp_bit_slice.sv
module cmp_bit_slice
  import cmp_pkg::*;
#(
  parameter int SLICE_FORM = FORM_SOP
) (
  input  logic     aBit,
  input  logic     bBit,
  input  cmpLink_t linkIn,
  output cmpLink_t linkOut
);

  logic zGt, zLt;

  generate
    if (SLICE_FORM == FORM_NAND) begin : g_nand
      cmp_slice_nand u_cell (
        .aBit (aBit),
        .bBit (bBit),
        .inGt (linkIn.gt),
        .inLt (linkIn.lt),
        .outGt(zGt),
        .outLt(zLt)
      );
    end else begin : g_sop
      cmp_slice_sop u_cell (
        .aBit (aBit),
        .bBit (bBit),
        .inGt (linkIn.gt),
        .inLt (linkIn.lt),
        .outGt(zGt),
        .outLt(zLt)
      );
    end
  endgenerate

  assign linkOut = '{gt: zGt, lt: zLt};

  // Cell rule checks (R6) and legal-code propagation (R4)
  always_comb begin
    if (aBit && !bBit) begin
      p_cell_over_gt_r6: assert (linkOut == CODE_GT)
        else $error("cell with A>B bit did not output 10");
    end else if (!aBit && bBit) begin
      p_cell_over_lt_r6: assert (linkOut == CODE_LT)
        else $error("cell with A<B bit did not output 01");
    end else begin
      p_cell_pass_r6: assert (linkOut == linkIn)
        else $error("cell with equal bits altered the code");
    end
    if (linkIn != CODE_BAD) begin
      p_cell_no_code11_r4: assert (linkOut != CODE_BAD)
        else $error("cell produced code 11 from a legal input");
    end
  end

endmodule

// File: rtl/cmp_ripple_chain.sv
module cmp_ripple_chain
  import cmp_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int SLICE_FORM = FORM_SOP
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output cmpLink_t         resLink
);

  localparam int NUM_LINKS = WIDTH + 1;

  cmpLink_t chainLink [NUM_LINKS];

  assign chainLink[0] = LINK_EQUAL;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      cmp_bit_slice #(.SLICE_FORM(SLICE_FORM)) u_slice (
        .aBit   (opA[i]),
        .bBit   (opB[i]),
        .linkIn (chainLink[i]),
        .linkOut(chainLink[i+1])
      );
    end
  endgenerate

  assign resLink = chainLink[NUM_LINKS-1];

endmodule

// File: rtl/cmp_result_decode.sv
module cmp_result_decode
  import cmp_pkg::*;
(
  input  cmpLink_t   resLink,
  output logic [1:0] resCode,
  output logic       aGreater,
  output logic       aLess,
  output logic       aEqual
);

  always_comb begin
    resCode  = {resLink.gt, resLink.lt};
    aGreater = resLink.gt & ~resLink.lt;
    aLess    = resLink.lt & ~resLink.gt;
    aEqual   = ~resLink.gt & ~resLink.lt;
  end

endmodule

// File: rtl/ripple_mag_cmp.sv
module ripple_mag_cmp
  import cmp_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int SLICE_FORM = FORM_SOP
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [1:0]       resCode,
  output logic             aGreater,
  output logic             aLess,
  output logic             aEqual
);

  cmpLink_t resLink;

  cmp_ripple_chain #(
    .WIDTH     (WIDTH),
    .SLICE_FORM(SLICE_FORM)
  ) u_chain (
    .opA    (opA),
    .opB    (opB),
    .resLink(resLink)
  );

  cmp_result_decode u_decode (
    .resLink (resLink),
    .resCode (resCode),
    .aGreater(aGreater),
    .aLess   (aLess),
    .aEqual  (aEqual)
  );

  // Operand-level checks against a behavioural comparison
  always_comb begin
    if (opA > opB) begin
      p_greater_r1: assert (resCode == CODE_GT)
        else $error("opA>opB but code is not 10");
    end else if (opA < opB) begin
      p_less_r2: assert (resCode == CODE_LT)
        else $error("opA<opB but code is not 01");
    end else begin
      p_equal_r3: assert (resCode == CODE_EQ)
        else $error("operands equal but code is not 00");
    end
    p_no_code11_r4: assert (resCode != CODE_BAD)
      else $error("result code 11 seen");
    p_flags_onehot_r5: assert ($countones({aGreater, aLess, aEqual}) == 1)
      else $error("result flags not one-hot");
  end

endmodule

// File: tb/ripple_mag_cmp_tb_top.sv
module ripple_mag_cmp_tb_top;
  import cmp_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  // stimulus nets
  logic [3:0]  a4, b4;
  logic [31:0] a32, b32;
  logic        a1, b1;
  logic [3:0]  sl;

  logic [1:0]  code4, codeN4, code32, codeS32, code1;
  logic        gt4, lt4, eq4;
  logic        unusedG0, unusedL0, unusedE0;
  logic        unusedG1, unusedL1, unusedE1;
  logic        unusedG2, unusedL2, unusedE2;
  logic        unusedG3, unusedL3, unusedE3;
  logic        sopGt, sopLt, nandGt, nandLt;

  ripple_mag_cmp #(.WIDTH(4), .SLICE_FORM(FORM_SOP)) dut_i (
    .opA(a4), .opB(b4), .resCode(code4),
    .aGreater(gt4), .aLess(lt4), .aEqual(eq4));

  ripple_mag_cmp #(.WIDTH(4), .SLICE_FORM(FORM_NAND)) nand4_i (
    .opA(a4), .opB(b4), .resCode(codeN4),
    .aGreater(unusedG0), .aLess(unusedL0), .aEqual(unusedE0));

  ripple_mag_cmp #(.WIDTH(32), .SLICE_FORM(FORM_NAND)) wide_i (
    .opA(a32), .opB(b32), .resCode(code32),
    .aGreater(unusedG1), .aLess(unusedL1), .aEqual(unusedE1));

  ripple_mag_cmp #(.WIDTH(32), .SLICE_FORM(FORM_SOP)) wideSop_i (
    .opA(a32), .opB(b32), .resCode(codeS32),
    .aGreater(unusedG2), .aLess(unusedL2), .aEqual(unusedE2));

  ripple_mag_cmp #(.WIDTH(1), .SLICE_FORM(FORM_SOP)) bit1_i (
    .opA(a1), .opB(b1), .resCode(code1),
    .aGreater(unusedG3), .aLess(unusedL3), .aEqual(unusedE3));

  cmp_slice_sop sliceSop_i (
    .aBit(sl[3]), .bBit(sl[2]), .inGt(sl[1]), .inLt(sl[0]),
    .outGt(sopGt), .outLt(sopLt));

  cmp_slice_nand sliceNand_i (
    .aBit(sl[3]), .bBit(sl[2]), .inGt(sl[1]), .inLt(sl[0]),
    .outGt(nandGt), .outLt(nandLt));

  typedef struct {
    logic [1:0] exp4;
    logic [1:0] exp32;
    logic [1:0] exp1;
    logic [1:0] expEqn;
    logic [1:0] expRule;
  } item_t;

  item_t scq[$];
  int nChecks = 0;
  int nFail   = 0;
  bit doneFlag = 1'b0;
  bit summaryDone = 1'b0;

  function automatic logic [1:0] refCode(logic [31:0] x, logic [31:0] y);
    if (x > y) return 2'b10;
    if (x < y) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] x4, logic [3:0] y4, logic [31:0] x32,
                       logic [31:0] y32, logic x1, logic y1, logic [3:0] s);
    item_t it;
    @(posedge clk);
    #1;
    a4 = x4; b4 = y4; a32 = x32; b32 = y32; a1 = x1; b1 = y1; sl = s;
    it.exp4  = refCode({28'd0, x4}, {28'd0, y4});
    it.exp32 = refCode(x32, y32);
    it.exp1  = refCode({31'd0, x1}, {31'd0, y1});
    // R7 equations
    it.expEqn[1] = (s[3] & ~s[2]) | (s[3] & s[1]) | (~s[2] & s[1]);
    it.expEqn[0] = (~s[3] & s[2]) | (~s[3] & s[0]) | (s[2] & s[0]);
    // R6 cell rule
    if (s[3] & ~s[2])      it.expRule = 2'b10;
    else if (~s[3] & s[2]) it.expRule = 2'b01;
    else                   it.expRule = s[1:0];
    scq.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (scq.size() > 0) begin
        item_t it;
        it = scq.pop_front();
        case (it.exp4)
          2'b10:   chk("R1", {30'd0, code4}, {30'd0, it.exp4});
          2'b01:   chk("R2", {30'd0, code4}, {30'd0, it.exp4});
          default: chk("R3", {30'd0, code4}, {30'd0, it.exp4});
        endcase
        chk("R4", {31'd0, (code4 == 2'b11) || (code32 == 2'b11)}, 32'd0);
        chk("R5", {29'd0, gt4, lt4, eq4},
            {29'd0, it.exp4 == 2'b10, it.exp4 == 2'b01, it.exp4 == 2'b00});
        chk("R8", {30'd0, codeN4}, {30'd0, it.exp4});
        chk("R10", {30'd0, code32}, {30'd0, it.exp32});
        chk("R8", {30'd0, codeS32}, {30'd0, code32});
        chk("R9", {30'd0, code1}, {30'd0, it.exp1});
        chk("R7", {30'd0, sopGt, sopLt}, {30'd0, it.expEqn});
        chk("R8", {30'd0, nandGt, nandLt}, {30'd0, sopGt, sopLt});
        chk("R6", {30'd0, nandGt, nandLt}, {30'd0, it.expRule});
      end
    end
  end

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!doneFlag) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=running expected=done");
      finishRun();
    end
  end

  // driver
  initial begin
    a4 = '0; b4 = '0; a32 = '0; b32 = '0; a1 = 1'b0; b1 = 1'b0; sl = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-state pattern: all zero operands give equal (R3)
    drive(4'd0, 4'd0, 32'd0, 32'd0, 1'b0, 1'b0, 4'd0);
    // exhaustive 4-bit, 1-bit and cell sweep
    for (int i = 0; i < 256; i++) begin
      logic [7:0] v;
      logic [31:0] r;
      v = i[7:0];
      r = $urandom;
      drive(v[7:4], v[3:0], r, (i % 3 == 0) ? r : $urandom,
            v[7], v[0], v[3:0]);
    end
    // directed R10 corners
    drive(4'd8, 4'd7, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b0, 4'b1011);
    drive(4'd14, 4'd15, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, 1'b1, 4'b0111);
    drive(4'd15, 4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'b1111);
    drive(4'd1, 4'd0, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b1, 4'b0011);
    // random 32-bit pairs, some one bit apart
    for (int k = 0; k < 400; k++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = (k % 4 == 0) ? (x ^ (32'd1 << (k % 32))) : $urandom;
      drive(x[3:0], y[3:0], x, y, x[5], y[5], x[11:8]);
    end
    @(posedge clk);
    while (scq.size() > 0) @(posedge clk);
    @(posedge clk);
    doneFlag = 1'b1;
    finishRun();
  end

endmodule